// File: doc/BRIEF.md
# Readback Register with Polarity Control

This block is a word-wide edge-triggered storage register that sits on a shared data bus. While its active-low enable is asserted, each rising clock edge takes the word on the bus into the register. With both enable and the active-low read input asserted, the register drives its stored word back onto that same bus, so software or a neighbouring agent can read back what was written. For synthesis the bus is split into a data-in vector, a data-out vector and a drive-enable, with the tri-state resolution left to the surrounding fabric.

A second, separate output port presents the stored word either true or bitwise inverted, chosen by a polarity input. That port can be released to high impedance with an active-low output enable, and it is modelled as a value plus a drive-enable. Releasing it has no effect on the register itself. An active-low asynchronous clear zeroes the stored word and overrides every other function. The enable input is meant to change only while the clock is high.

Top module: `readback_polarity_reg`

## Requirements
- R1: On a rising clock edge with `en_n` low and `clr_n` high, the stored word takes the value on `bus_in`; the new word appears on `bus_out` after that edge.
- R2: With `en_n` high, a rising clock edge leaves the stored word unchanged and `bus_drive` is 0 whatever `rd_n` is.
- R3: `bus_drive` is 1 exactly when `en_n` and `rd_n` are both 0; `bus_out` always carries the stored word in true polarity, independent of `pol_true`.
- R4: When `pol_true` is 1, `q_out` equals the stored word; when it is 0, `q_out` equals the bitwise inverse of the stored word.
- R5: `q_drive` equals the inverse of `oe_n`; `oe_n` has no effect on loading, holding or clearing the stored word.
- R6: While `clr_n` is 0 the stored word is all zeros, reached without waiting for a clock edge, and a clock edge with `en_n` low does not load during that time.
- R7: When readback is active at a clock edge, the register captures the word it is itself driving, so its contents stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capture on rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| en_n | input | 1 | Register enable for load and readback, active low |
| rd_n | input | 1 | Readback request, active low |
| oe_n | input | 1 | Output-port enable, active low |
| pol_true | input | 1 | 1: output port true; 0: output port inverted |
| bus_in | input | W | Word sampled from the shared bus |
| bus_out | output | W | Stored word, true polarity, for driving the bus |
| bus_drive | output | 1 | Bus drive-enable for readback |
| q_out | output | W | Output-port value after polarity selection |
| q_drive | output | 1 | Output-port drive-enable |

## Verification
The bench builds the block with its default width W = 8, which keeps every bit position visible in each check while letting random words hit the all-ones and all-zeros patterns where the polarity inversion is most telling. The bench resolves the bus itself, feeding the register's own word back into `bus_in` whenever `bus_drive` is high, so readback coinciding with a capture edge is exercised naturally. Directed passes cover a clear pulled low mid-cycle with enable held low across an edge, loads taken with the output port released, and readback requested with enable high.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  // Decoded per-cycle control, derived from the active-low pins.
  typedef struct packed {
    logic load;   // capture at next rising edge
    logic read;   // drive stored word onto the bus
  } rbr_ctrl_t;

  function automatic rbr_ctrl_t rbr_decode(input logic en_n, input logic rd_n);
    rbr_ctrl_t c;
    c.load = ~en_n;
    c.read = ~en_n & ~rd_n;
    return c;
  endfunction

  function automatic logic rbr_port_on(input logic oe_n);
    return ~oe_n;
  endfunction

endpackage

// File: rtl/rbr_store.sv
module rbr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      q <= '0;
    else if (load)
      q <= d;
  end

endmodule

// File: rtl/rbr_bus_ctrl.sv
module rbr_bus_ctrl #(
  parameter int W = 8
) (
  input  logic         en_n,
  input  logic         rd_n,
  input  logic [W-1:0] stored,
  output logic         load_evt,
  output logic         read_evt,
  output logic [W-1:0] bus_out,
  output logic         bus_drive
);
  import rbr_pkg::*;

  rbr_ctrl_t ctrl;

  always_comb begin
    ctrl      = rbr_decode(en_n, rd_n);
    load_evt  = ctrl.load;
    read_evt  = ctrl.read;
    bus_drive = ctrl.read;
    bus_out   = stored;   // always true polarity
  end

endmodule

// File: rtl/rbr_out_stage.sv
module rbr_out_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] stored,
  input  logic         pol_true,
  input  logic         oe_n,
  output logic [W-1:0] q_out,
  output logic         q_drive
);
  import rbr_pkg::*;

  function automatic logic [W-1:0] present(input logic [W-1:0] w, input logic pol);
    return w ^ {W{~pol}};
  endfunction

  always_comb begin
    q_out   = present(stored, pol_true);
    q_drive = rbr_port_on(oe_n);
  end

endmodule

// File: rtl/readback_polarity_reg.sv
module readback_polarity_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en_n,
  input  logic         rd_n,
  input  logic         oe_n,
  input  logic         pol_true,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  output logic [W-1:0] q_out,
  output logic         q_drive
);

  logic [W-1:0] stored_word;
  logic         load_evt;
  logic         read_evt;

  rbr_bus_ctrl #(.W(W)) u_ctrl (
    .en_n      (en_n),
    .rd_n      (rd_n),
    .stored    (stored_word),
    .load_evt  (load_evt),
    .read_evt  (read_evt),
    .bus_out   (bus_out),
    .bus_drive (bus_drive)
  );

  rbr_store #(.W(W)) u_store (
    .clk   (clk),
    .clr_n (clr_n),
    .load  (load_evt),
    .d     (bus_in),
    .q     (stored_word)
  );

  rbr_out_stage #(.W(W)) u_out (
    .stored   (stored_word),
    .pol_true (pol_true),
    .oe_n     (oe_n),
    .q_out    (q_out),
    .q_drive  (q_drive)
  );

endmodule

// File: rtl/rbr_checker.sv
module rbr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic         en_n,
  input logic         rd_n,
  input logic         oe_n,
  input logic         pol_true,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_drive,
  input logic [W-1:0] q_out,
  input logic         q_drive,
  input logic [W-1:0] stored,
  input logic         load_evt,
  input logic         read_evt
);

  a_r1_load: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> (bus_out == $past(bus_in)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!clr_n)
    en_n |=> $stable(bus_out));

  a_r2_no_drive: assert property (@(posedge clk) disable iff (!clr_n)
    en_n |-> !bus_drive);

  a_r3_drive_cond: assert property (@(posedge clk) disable iff (!clr_n)
    bus_drive |-> (!en_n && !rd_n && read_evt));

  a_r3_true_pol: assert property (@(posedge clk) disable iff (!clr_n)
    bus_out == stored);

  a_r4_polarity: assert property (@(posedge clk) disable iff (!clr_n)
    q_out == (pol_true ? bus_out : ~bus_out));

  a_r5_port_en: assert property (@(posedge clk) disable iff (!clr_n)
    q_drive == !oe_n);

  a_r6_clear: assert property (@(posedge clk)
    !clr_n |-> (bus_out == '0));

  a_r7_readback_keep: assert property (@(posedge clk) disable iff (!clr_n)
    (bus_drive && (bus_in == bus_out)) |=> $stable(bus_out));

endmodule

bind readback_polarity_reg rbr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .en_n      (en_n),
  .rd_n      (rd_n),
  .oe_n      (oe_n),
  .pol_true  (pol_true),
  .bus_in    (bus_in),
  .bus_out   (bus_out),
  .bus_drive (bus_drive),
  .q_out     (q_out),
  .q_drive   (q_drive),
  .stored    (stored_word),
  .load_evt  (load_evt),
  .read_evt  (read_evt)
);

// File: tb/tb_readback_polarity_reg.sv
`timescale 1ns/1ps
module tb_readback_polarity_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n, en_n, rd_n, oe_n, pol_true;
  logic [W-1:0] tb_data;
  logic [W-1:0] bus_in, bus_out, q_out;
  logic         bus_drive, q_drive;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [W-1:0] model;
  logic         prev_en_n;
  logic [W-1:0] prev_bus;

  always #2 clk = ~clk;   // 250 MHz

  // Bus resolution: the register's own word wins while it drives.
  assign bus_in = bus_drive ? bus_out : tb_data;

  readback_polarity_reg #(.W(W)) dut (
    .clk(clk), .clr_n(clr_n), .en_n(en_n), .rd_n(rd_n), .oe_n(oe_n),
    .pol_true(pol_true), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drive(bus_drive), .q_out(q_out), .q_drive(q_drive)
  );

  function automatic logic [W-1:0] exp_q(input logic [W-1:0] w, input logic pol);
    return pol ? w : ~w;
  endfunction

  function automatic logic exp_drive(input logic e, input logic r);
    return (e == 1'b0) && (r == 1'b0);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 bus_drive", W'(bus_drive), W'(exp_drive(en_n, rd_n)));
    chk("R3 bus_out",   bus_out, model);
    chk("R4 q_out",     q_out, exp_q(model, pol_true));
    chk("R5 q_drive",   W'(q_drive), W'(!oe_n));
  endtask

  // One clock: edge (model update), apply inputs with clock high, check.
  task automatic cyc(input logic e, input logic r, input logic o,
                     input logic p, input logic [W-1:0] d);
    @(posedge clk);
    if (!prev_en_n) model = prev_bus;   // R1 / R7
    #0.5;
    en_n = e; rd_n = r; oe_n = o; pol_true = p; tb_data = d;
    #0.5;
    check_all();
    prev_en_n = en_n;
    prev_bus  = bus_in;   // R7: equals model when driving
    if (exp_drive(e, r)) chk("R7 bus word", bus_in, model);
  endtask

  task automatic mid_clear();
    @(posedge clk);
    if (!prev_en_n) model = prev_bus;
    #0.5;
    en_n = 1'b1; rd_n = 1'b1; tb_data = 8'hA5;
    #0.5;
    clr_n = 1'b0;
    #0.5;
    model = '0;
    chk("R6 async clear", bus_out, '0);
    chk("R6 q_out after clear", q_out, exp_q('0, pol_true));
    // enable low across an edge while clear held
    @(posedge clk);
    #0.5;
    en_n = 1'b0; tb_data = 8'h3C;
    @(posedge clk);
    #1;
    chk("R6 clear overrides load", bus_out, '0);
    en_n = 1'b1;
    clr_n = 1'b1;
    prev_en_n = 1'b1;
    prev_bus  = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    clr_n = 1'b0; en_n = 1'b1; rd_n = 1'b1; oe_n = 1'b0; pol_true = 1'b1;
    tb_data = '0; model = '0; prev_en_n = 1'b1; prev_bus = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset word", bus_out, '0);
    chk("R2 reset no drive", W'(bus_drive), '0);
    @(posedge clk); #1;
    clr_n = 1'b1;

    // R1 plain load, then R2 hold with readback requested but enable high
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h5A);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R2 held word", bus_out, 8'h5A);
    chk("R2 no drive enable high", W'(bus_drive), '0);

    // R5 load with port released, then R4 polarity toggling
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hC3);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h11);
    chk("R5 load while port off", bus_out, 8'hC3);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h11);
    chk("R4 inverted", q_out, 8'h3C);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    chk("R4 true", q_out, 8'hC3);

    // R7 readback across several edges
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h99);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h66);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h66);
    chk("R7 readback keeps word", bus_out, 8'hC3);

    // R6 clear in mid-cycle
    mid_clear();
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h77);
    chk("R6 word after release", bus_out, '0);

    // boundary words
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R4 all ones inverted", q_out, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h12);
    chk("R1 all zeros loaded", q_out, 8'hFF);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r[0] & r[3], r[1], 1'($urandom), r[2], W'($urandom));
      if (i == 200) mid_clear();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule